// File: doc/BRIEF.md
# Pointer-Offset Byte Instruction Executor

This block carries out three single-word byte instructions whose operand lives in data memory at the address formed by a 12-bit base pointer plus an 8-bit literal offset carried in the instruction: an add of the working register W to the byte, a single-bit set, and a fill with all ones. A host hands it one 16-bit instruction word with a valid strobe whenever `busy` is low. The block holds W, the base pointer and five arithmetic flags, and drives a synchronous single-port data-memory interface.

Every legal instruction passes through four phases, one clock each: decode and address formation, memory read, data processing, and write of the destination (W or the memory byte). Words that match none of the three encodings, or that carry an offset above 95, are reported on `illegal` and leave all state untouched. W and the base pointer can be loaded from dedicated ports while the block is idle.

Top module: `ilo_exec`

## Requirements
- R1: The add word `0010 01d0 kkkk kkkk` with d=0 sets W to (W + byte) mod 256 and leaves the memory byte unchanged.
- R2: The add word with d=1 writes (W + byte) mod 256 back to the addressed byte and leaves W unchanged.
- R3: The add word updates `flags_out` = {N, OV, Z, DC, C} (bit 4 down to bit 0): C is the carry out of bit 7, DC the carry out of bit 3, OV the two's-complement overflow, N bit 7 of the result, Z set when the 8-bit result is zero.
- R4: The bit-set word `1000 bbb0 kkkk kkkk` sets bit b of the addressed byte, leaves the other bits, W and the flags unchanged.
- R5: The fill word `0110 1000 kkkk kkkk` writes FFh to the addressed byte and leaves W and the flags unchanged.
- R6: The operand address is (pointer + k) mod 4096, k being the low instruction byte.
- R7: A word with k above 95 or with no matching encoding raises `illegal` one cycle after acceptance, keeps it until the next acceptance, performs no memory write and changes neither W nor the flags; `busy` is high for one cycle only.
- R8: A legal instruction keeps `busy` high for exactly four cycles after the accepting edge; `mem_rd_en` is high in the second of them, `mem_wr_en` only in the fourth; a valid word offered while `busy` is high is ignored.
- R9: After synchronous reset W, the pointer and the flags are zero and `busy` and `illegal` are low.
- R10: `ptr_ld` and `w_ld` load the pointer and W when `busy` is low and are ignored while it is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| instr_valid | input | 1 | Instruction word offered |
| instr | input | 16 | Instruction word |
| busy | output | 1 | Instruction in progress; new words not accepted |
| illegal | output | 1 | Last accepted word was not executable |
| ptr_ld | input | 1 | Load base pointer |
| ptr_val | input | 12 | Base pointer load value |
| w_ld | input | 1 | Load working register |
| w_val | input | 8 | Working register load value |
| w_out | output | 8 | Working register contents |
| flags_out | output | 5 | {N, OV, Z, DC, C} |
| mem_addr | output | 12 | Data-memory address |
| mem_rd_en | output | 1 | Read strobe, data returned the next cycle |
| mem_rdata | input | 8 | Read data |
| mem_wr_en | output | 1 | Write strobe |
| mem_wdata | output | 8 | Write data |

## Verification
The write phase of one instruction and the arrival of the next valid word can land in the same cycle, as can the register-load strobes and an instruction in flight. The bench keeps `instr_valid` high with a second, conflicting fill word, and pulses `ptr_ld` and `w_ld`, on every busy cycle of a running instruction, including its write phase. It then judges by the ports: the intruding word's target byte must still hold its old value, the pointer must be unchanged (shown by a later fill landing at the old address), and W must equal its prior value.

// File: rtl/ilo_pkg.sv
// Shared types for the pointer-offset byte instruction executor.
// Assumes an 8-bit data path and a four-phase instruction sequence.
package ilo_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_DECODE,
        PH_READ,
        PH_PROC,
        PH_WRITE
    } phase_t;

    typedef enum logic [1:0] {
        OP_ADD,
        OP_BSET,
        OP_FILL,
        OP_NONE
    } op_t;

    typedef struct packed {
        logic n;
        logic ov;
        logic z;
        logic dc;
        logic c;
    } flags_t;

endpackage

// File: rtl/ilo_decode.sv
// Instruction decoder: classifies a 16-bit word into add, bit-set, fill or
// none, extracts the offset, bit index and destination, and flags words
// whose offset exceeds K_MAX. Purely combinational.
module ilo_decode
    import ilo_pkg::*;
#(
    parameter int K_MAX = 95
) (
    input  logic [15:0] word,
    output op_t         op,
    output logic        dest_mem,
    output logic [2:0]  bit_sel,
    output logic [7:0]  offset,
    output logic        bad
);
    localparam logic [7:0] KLIM = 8'(K_MAX);

    // Match the three encodings and pick the destination.
    always_comb begin
        op       = OP_NONE;
        dest_mem = 1'b1;
        if (word[15:10] == 6'b001001 && !word[8]) begin
            op       = OP_ADD;
            dest_mem = word[9];
        end else if (word[15:12] == 4'b1000 && !word[8]) begin
            op = OP_BSET;
        end else if (word[15:8] == 8'h68) begin
            op = OP_FILL;
        end
    end

    assign bit_sel = word[11:9];
    assign offset  = word[7:0];
    assign bad     = (op == OP_NONE) || (offset > KLIM);

endmodule

// File: rtl/ilo_alu.sv
// Operand processor: forms the add result with its five flags, the
// single-bit set and the all-ones fill. Assumes DATA_W is even.
module ilo_alu
    import ilo_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  op_t               op,
    input  logic [DATA_W-1:0] w,
    input  logic [DATA_W-1:0] m,
    input  logic [2:0]        bit_sel,
    output logic [DATA_W-1:0] result,
    output flags_t            flags
);
    localparam int HALF = DATA_W / 2;

    logic [DATA_W:0] sum;
    logic [HALF:0]   nib;

    // Full and lower-half sums for carry and digit carry.
    always_comb begin
        sum = {1'b0, w} + {1'b0, m};
        nib = {1'b0, w[HALF-1:0]} + {1'b0, m[HALF-1:0]};
    end

    // Result select per operation.
    always_comb begin
        case (op)
            OP_ADD:  result = sum[DATA_W-1:0];
            OP_BSET: result = m | (DATA_W'(1) << bit_sel);
            OP_FILL: result = '1;
            default: result = m;
        endcase
    end

    // Add flags; meaningful only for OP_ADD.
    always_comb begin
        flags.c  = sum[DATA_W];
        flags.dc = nib[HALF];
        flags.n  = sum[DATA_W-1];
        flags.z  = (sum[DATA_W-1:0] == '0);
        flags.ov = (w[DATA_W-1] == m[DATA_W-1]) &&
                   (sum[DATA_W-1] != w[DATA_W-1]);
    end

endmodule

// File: rtl/ilo_seq.sv
// Phase sequencer: idle, decode, read, process, write. An illegal word
// returns to idle straight from decode. Synchronous active-low reset.
module ilo_seq
    import ilo_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   start,
    input  logic   bad,
    output phase_t phase
);
    phase_t nxt;

    // Next-phase selection.
    always_comb begin
        case (phase)
            PH_IDLE:   nxt = start ? PH_DECODE : PH_IDLE;
            PH_DECODE: nxt = bad ? PH_IDLE : PH_READ;
            PH_READ:   nxt = PH_PROC;
            PH_PROC:   nxt = PH_WRITE;
            default:   nxt = PH_IDLE;
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) phase <= PH_IDLE;
        else        phase <= nxt;
    end

    a_r8_read_then_proc: assert property (@(posedge clk) disable iff (!rst_n)
        phase == PH_READ |=> phase == PH_PROC);
    a_r8_proc_then_write: assert property (@(posedge clk) disable iff (!rst_n)
        phase == PH_PROC |=> phase == PH_WRITE);

endmodule

// File: rtl/ilo_exec.sv
// Top of the pointer-offset byte instruction executor. Accepts one word
// when idle, forms address = pointer + offset (mod 2^ADDR_W), reads the
// byte, processes it and writes W or memory. Assumes the memory returns
// read data one cycle after mem_rd_en.
module ilo_exec
    import ilo_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 8,
    parameter int K_MAX  = 95
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              instr_valid,
    input  logic [15:0]       instr,
    output logic              busy,
    output logic              illegal,
    input  logic              ptr_ld,
    input  logic [ADDR_W-1:0] ptr_val,
    input  logic              w_ld,
    input  logic [DATA_W-1:0] w_val,
    output logic [DATA_W-1:0] w_out,
    output logic [4:0]        flags_out,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd_en,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              mem_wr_en,
    output logic [DATA_W-1:0] mem_wdata
);
    localparam int OFF_W = 8;

    phase_t            phase;
    logic              start;
    logic [15:0]       instr_q;
    op_t               dec_op, op_q;
    logic              dec_dest_mem, dest_mem_q;
    logic [2:0]        dec_bit, bit_q;
    logic [OFF_W-1:0]  dec_off;
    logic              dec_bad;
    logic [ADDR_W-1:0] ptr_q, ea_q;
    logic [DATA_W-1:0] w_q, result_q, alu_res;
    flags_t            flags_q, flags_new_q, alu_flags;
    logic              illegal_q;

    assign busy  = (phase != PH_IDLE);
    assign start = instr_valid && !busy;

    ilo_decode #(.K_MAX(K_MAX)) u_dec (
        .word     (instr_q),
        .op       (dec_op),
        .dest_mem (dec_dest_mem),
        .bit_sel  (dec_bit),
        .offset   (dec_off),
        .bad      (dec_bad)
    );

    ilo_alu #(.DATA_W(DATA_W)) u_alu (
        .op      (op_q),
        .w       (w_q),
        .m       (mem_rdata),
        .bit_sel (bit_q),
        .result  (alu_res),
        .flags   (alu_flags)
    );

    ilo_seq u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .bad   (dec_bad),
        .phase (phase)
    );

    // Capture the accepted word and track the illegal indication.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            instr_q   <= '0;
            illegal_q <= 1'b0;
        end else if (start) begin
            instr_q   <= instr;
            illegal_q <= 1'b0;
        end else if (phase == PH_DECODE) begin
            illegal_q <= dec_bad;
        end
    end

    // Latch decoded fields and the effective address in the decode phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q       <= OP_NONE;
            dest_mem_q <= 1'b0;
            bit_q      <= '0;
            ea_q       <= '0;
        end else if (phase == PH_DECODE) begin
            op_q       <= dec_op;
            dest_mem_q <= dec_dest_mem;
            bit_q      <= dec_bit;
            ea_q       <= ptr_q + {{(ADDR_W-OFF_W){1'b0}}, dec_off};
        end
    end

    // Register the processed byte and the candidate flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_q    <= '0;
            flags_new_q <= '0;
        end else if (phase == PH_PROC) begin
            result_q    <= alu_res;
            flags_new_q <= alu_flags;
        end
    end

    // Working register: write phase or idle load.
    always_ff @(posedge clk) begin
        if (!rst_n)                                  w_q <= '0;
        else if (phase == PH_WRITE && !dest_mem_q)  w_q <= result_q;
        else if (!busy && w_ld)                      w_q <= w_val;
    end

    // Flags: only the add updates them, in its write phase.
    always_ff @(posedge clk) begin
        if (!rst_n)                                  flags_q <= '0;
        else if (phase == PH_WRITE && op_q == OP_ADD) flags_q <= flags_new_q;
    end

    // Base pointer: loaded only while idle.
    always_ff @(posedge clk) begin
        if (!rst_n)              ptr_q <= '0;
        else if (!busy && ptr_ld) ptr_q <= ptr_val;
    end

    assign mem_addr  = ea_q;
    assign mem_rd_en = (phase == PH_READ);
    assign mem_wr_en = (phase == PH_WRITE) && dest_mem_q;
    assign mem_wdata = result_q;
    assign w_out     = w_q;
    assign flags_out = flags_q;
    assign illegal   = illegal_q;

    a_r8_rd_wr_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd_en && mem_wr_en));
    a_r8_accept_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && !busy) |=> busy);
    a_r8_write_is_last: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |=> !busy);
    a_r7_no_write_when_illegal: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> !mem_wr_en);
    a_r10_ptr_frozen_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(ptr_q));
    a_r1_w_frozen_before_write: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && phase != PH_WRITE) |=> $stable(w_q));
    a_r4_flags_kept_nonadd: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_WRITE && op_q != OP_ADD) |=> $stable(flags_q));

endmodule

// File: tb/ilo_exec_bench.sv
`timescale 1ns/1ps
module ilo_exec_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_valid = 1'b0;
    logic [15:0] instr = '0;
    logic        busy, illegal;
    logic        ptr_ld = 1'b0;
    logic [11:0] ptr_val = '0;
    logic        w_ld = 1'b0;
    logic [7:0]  w_val = '0;
    logic [7:0]  w_out;
    logic [4:0]  flags_out;
    logic [11:0] mem_addr;
    logic        mem_rd_en, mem_wr_en;
    logic [7:0]  mem_rdata, mem_wdata;
    logic [7:0]  mem [4096];
    int          n_total = 0;
    int          n_fail = 0;

    always #2.5 clk = ~clk;

    ilo_exec u_ilo_exec (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr(instr),
        .busy(busy), .illegal(illegal), .ptr_ld(ptr_ld), .ptr_val(ptr_val),
        .w_ld(w_ld), .w_val(w_val), .w_out(w_out), .flags_out(flags_out),
        .mem_addr(mem_addr), .mem_rd_en(mem_rd_en), .mem_rdata(mem_rdata),
        .mem_wr_en(mem_wr_en), .mem_wdata(mem_wdata)
    );

    // Synchronous data memory model.
    always @(posedge clk) begin
        if (mem_wr_en) mem[mem_addr] <= mem_wdata;
        if (mem_rd_en) mem_rdata <= mem[mem_addr];
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_total++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [4:0] add_flags(input int w, input int m);
        int s, sv;
        logic n, ov, z, dc, c;
        s  = w + m;
        sv = (w > 127 ? w - 256 : w) + (m > 127 ? m - 256 : m);
        c  = (s > 255);
        dc = ((w % 16) + (m % 16)) > 15;
        ov = (sv > 127) || (sv < -128);
        n  = (s % 256) >= 128;
        z  = (s % 256) == 0;
        return {n, ov, z, dc, c};
    endfunction

    task automatic load_ptr(input logic [11:0] v);
        @(negedge clk); ptr_ld = 1'b1; ptr_val = v;
        @(negedge clk); ptr_ld = 1'b0;
    endtask

    task automatic load_w(input logic [7:0] v);
        @(negedge clk); w_ld = 1'b1; w_val = v;
        @(negedge clk); w_ld = 1'b0;
    endtask

    // Issue a word; optionally harass the block while busy. Returns busy cycles
    // and the cycle (1-based) of the read and write strobes.
    task automatic run(input logic [15:0] word, input bit harass,
                       input logic [15:0] other, output int cyc,
                       output int rd_at, output int wr_at);
        cyc = 0; rd_at = 0; wr_at = 0;
        @(negedge clk); instr_valid = 1'b1; instr = word;
        @(negedge clk); instr_valid = 1'b0;
        while (busy && cyc < 20) begin
            cyc++;
            if (mem_rd_en) rd_at = cyc;
            if (mem_wr_en) wr_at = cyc;
            if (harass) begin
                instr_valid = 1'b1; instr = other;
                ptr_ld = 1'b1; ptr_val = 12'h123;
                w_ld = 1'b1; w_val = 8'hA5;
            end
            @(negedge clk);
            instr_valid = 1'b0; ptr_ld = 1'b0; w_ld = 1'b0;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_total++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

    initial begin
        int cyc, rd_at, wr_at;
        logic [7:0] old;
        logic [4:0] fl;
        for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: reset state
        chk(w_out == 0, "R9 W after reset", w_out, 0);
        chk(flags_out == 0, "R9 flags after reset", flags_out, 0);
        chk(!busy && !illegal, "R9 busy/illegal after reset", {busy, illegal}, 0);
        run(16'h6805, 0, 0, cyc, rd_at, wr_at);
        chk(mem[5] == 8'hFF, "R9 pointer zero after reset (fill at 005)", mem[5], 8'hFF);
        // R8: phase timing
        chk(cyc == 4, "R8 busy cycles", cyc, 4);
        chk(rd_at == 2, "R8 read phase", rd_at, 2);
        chk(wr_at == 4, "R8 write phase", wr_at, 4);

        // R1/R3: worked example
        load_ptr(12'hA00); load_w(8'h17); mem[12'hA2C] = 8'h20;
        run(16'h242C, 0, 0, cyc, rd_at, wr_at);
        chk(w_out == 8'h37, "R1 example W", w_out, 8'h37);
        chk(mem[12'hA2C] == 8'h20, "R1 example byte kept", mem[12'hA2C], 8'h20);
        chk(wr_at == 0, "R1 no memory write", wr_at, 0);

        // R1/R2/R3 sweep
        for (int wi = 0; wi < 16; wi++) begin
            for (int mi = 0; mi < 52; mi++) begin
                int wv, mv, k;
                wv = wi * 17; mv = mi * 5; k = (wi * 7 + mi) % 96;
                mem[12'hA00 + k] = mv[7:0];
                load_w(wv[7:0]);
                run({8'h24, k[7:0]}, 0, 0, cyc, rd_at, wr_at);
                chk(w_out == 8'((wv + mv) % 256), "R1 W sum", w_out, (wv + mv) % 256);
                chk(mem[12'hA00 + k] == mv[7:0], "R1 byte kept", mem[12'hA00 + k], mv);
                chk(flags_out == add_flags(wv, mv), "R3 flags d=0", flags_out, add_flags(wv, mv));
                load_w(wv[7:0]);
                run({8'h26, k[7:0]}, 0, 0, cyc, rd_at, wr_at);
                chk(mem[12'hA00 + k] == 8'((wv + mv) % 256), "R2 byte sum",
                    mem[12'hA00 + k], (wv + mv) % 256);
                chk(w_out == wv[7:0], "R2 W kept", w_out, wv);
                chk(flags_out == add_flags(wv, mv), "R3 flags d=1", flags_out, add_flags(wv, mv));
            end
        end

        // R4: bit-set example and sweep; flags and W must not move
        load_w(8'h3C);
        mem[12'hA0A] = 8'h55;
        fl = flags_out;
        run(16'h8E0A, 0, 0, cyc, rd_at, wr_at);
        chk(mem[12'hA0A] == 8'hD5, "R4 example bit 7", mem[12'hA0A], 8'hD5);
        for (int b = 0; b < 8; b++) begin
            for (int mi = 0; mi < 8; mi++) begin
                int mv;
                mv = mi * 37 % 256;
                mem[12'hA00 + 40 + b] = mv[7:0];
                run({4'b1000, b[2:0], 1'b0, 8'(40 + b)}, 0, 0, cyc, rd_at, wr_at);
                chk(mem[12'hA00 + 40 + b] == 8'(mv | (1 << b)), "R4 bit set",
                    mem[12'hA00 + 40 + b], mv | (1 << b));
                chk(flags_out == fl && w_out == 8'h3C, "R4 flags/W kept",
                    {flags_out, w_out}, {fl, 8'h3C});
            end
        end

        // R5: fill at both offset limits
        run(16'h6800, 0, 0, cyc, rd_at, wr_at);
        chk(mem[12'hA00] == 8'hFF, "R5 fill k=0", mem[12'hA00], 8'hFF);
        run(16'h685F, 0, 0, cyc, rd_at, wr_at);
        chk(mem[12'hA5F] == 8'hFF, "R5 fill k=95", mem[12'hA5F], 8'hFF);
        chk(flags_out == fl && w_out == 8'h3C, "R5 flags/W kept", {flags_out, w_out}, {fl, 8'h3C});

        // R6: address wrap
        load_ptr(12'hFF0); mem[12'h010] = 8'h00;
        run(16'h6820, 0, 0, cyc, rd_at, wr_at);
        chk(mem[12'h010] == 8'hFF, "R6 wrapped address", mem[12'h010], 8'hFF);

        // R7: illegal words
        load_ptr(12'hA00); mem[12'hA60] = 8'h11;
        foreach (mem[i]) begin end
        begin
            logic [15:0] bad [6];
            bad[0] = 16'h2660; bad[1] = 16'h0000; bad[2] = 16'hFFFF;
            bad[3] = 16'h2510; bad[4] = 16'h8110; bad[5] = 16'h6910;
            for (int i = 0; i < 6; i++) begin
                mem[12'hA10] = 8'h11;
                run(bad[i], 0, 0, cyc, rd_at, wr_at);
                chk(illegal, "R7 illegal raised", illegal, 1);
                chk(cyc == 1 && wr_at == 0, "R7 one busy cycle, no write", cyc, 1);
                chk(mem[12'hA10] == 8'h11 && mem[12'hA60] == 8'h11, "R7 memory kept",
                    mem[12'hA10], 8'h11);
                chk(w_out == 8'h3C && flags_out == fl, "R7 W/flags kept",
                    {flags_out, w_out}, {fl, 8'h3C});
            end
        end
        run(16'h6801, 0, 0, cyc, rd_at, wr_at);
        chk(!illegal, "R7 cleared by next legal word", illegal, 0);

        // R8/R10: intrusions during every busy cycle, write phase included
        mem[12'hA30] = 8'h00; mem[12'hA31] = 8'h44;
        run(16'h6830, 1, 16'h6831, cyc, rd_at, wr_at);
        chk(mem[12'hA30] == 8'hFF, "R8 running word completes", mem[12'hA30], 8'hFF);
        chk(mem[12'hA31] == 8'h44, "R8 word offered while busy ignored", mem[12'hA31], 8'h44);
        chk(w_out == 8'h3C, "R10 W load ignored while busy", w_out, 8'h3C);
        mem[12'hA32] = 8'h00;
        run(16'h6832, 0, 0, cyc, rd_at, wr_at);
        chk(mem[12'hA32] == 8'hFF, "R10 pointer load ignored while busy", mem[12'hA32], 8'hFF);
        old = mem[12'h123 + 8'h32];
        chk(old == 8'h00, "R10 no write at intruder pointer", old, 0);

        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end
endmodule